// File: doc/BRIEF.md
# Time-Base Divider with Tone Output

This block is one free-running binary divider that keeps time for the rest of the chip. It counts ticks from one of three places: a slow 32.768 kHz crystal input, the system clock itself, or the output of a timer's programmable prescaler. Fixed taps of the same counter give three results. A long overflow gives a clock-keeping tick every half second when the crystal is the source. A short overflow has one of four selectable intervals. A square-wave tone of 4 kHz or 2 kHz drives a buzzer.

The slow inputs are not used as clocks. Each one passes through a synchroniser and a rising-edge detector in the system clock domain, so every result comes out of system-clock registers. The overflow outputs are pulses one system clock wide. A change of the source select clears the divider, so the first interval after a switch is a full one.

Top module: `tbase_buzz_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, all three outputs are low.
- R2: Source select code 0 counts rising edges of the crystal input and code 2 counts rising edges of the prescaler input, each after synchronisation. Code 1 counts every system clock cycle.
- R3: The long overflow pulses once every 16384 counted ticks, and each pulse is one system clock wide.
- R4: The short overflow interval is 32, 128, 512 or 2048 counted ticks for short-select codes 0, 1, 2 and 3.
- R5: Each short overflow pulse is one system clock wide, and every long overflow pulse coincides with a short overflow pulse.
- R6: With tone enabled, tone-select 0 gives a square wave of period 8 ticks (divide-by-8, 4 kHz from the crystal) and tone-select 1 gives period 16 ticks (2 kHz). Both have equal high and low times.
- R7: With tone disabled, the buzzer output stays low while the divider keeps counting.
- R8: A change of the source select clears the divider in the cycle it is seen. With the system clock as the new source and short-select 0, the first short pulse is registered on the 32nd clock edge after the clearing edge.
- R9: Source select code 3 stops counting: no overflow pulses occur and the buzzer output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_i | input | 1 | 32.768 kHz crystal level, asynchronous |
| pre_i | input | 1 | Timer prescaler output level, asynchronous |
| src_sel_i | input | 2 | Count source: 0 crystal, 1 system clock, 2 prescaler, 3 stopped |
| short_sel_i | input | 2 | Short interval select: 0..3 for 32/128/512/2048 ticks |
| buzz_en_i | input | 1 | Tone enable |
| buzz_freq_i | input | 1 | Tone select: 0 divide-by-8, 1 divide-by-16 |
| ovf_long_o | output | 1 | Long overflow pulse |
| ovf_short_o | output | 1 | Short overflow pulse |
| buzz_o | output | 1 | Buzzer square wave |

## Verification
The assertions assume that each slow source holds every level for at least two system clock cycles. This keeps the one-wide pulse and the stable-count properties meaningful. The stimulus toggles the crystal input every 4 cycles and the prescaler input every 3 cycles, always on falling clock edges. All select and enable inputs change only on falling edges. The shortest interval, 32 ticks at one tick per cycle, keeps successive short pulses well apart, and the checks on pulse width depend on that.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_PRE  = 2'd2,
        SRC_OFF  = 2'd3
    } tb_src_e;

    localparam int CNT_W         = 14;  // 2^14 ticks per long overflow
    localparam int N_SHORT       = 4;
    localparam int SHORT_LOG_MIN = 5;   // 32 ticks
    localparam int SHORT_STEP    = 2;   // x4 per select code
    localparam int N_TONE        = 2;
    localparam int TONE_LOG_MIN  = 3;   // divide-by-8
    localparam int SYNC_STAGES   = 2;

    typedef struct packed {
        logic long_hit;
        logic short_hit;
    } tb_wrap_s;

    function automatic int short_log(input int code);
        return SHORT_LOG_MIN + SHORT_STEP * code;
    endfunction

    function automatic int tone_bit(input int code);
        return TONE_LOG_MIN - 1 + code;
    endfunction

endpackage

// File: rtl/tbase_edge_sync.sv
module tbase_edge_sync #(
    parameter int STAGES = tbase_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    a_r2_rise_one_wide: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tbase_src_sel.sv
module tbase_src_sel
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel_i,
    input  logic       xtal_rise_i,
    input  logic       pre_rise_i,
    output logic       tick_o,
    output logic       clr_o
);
    tb_src_e src_q;
    tb_src_e src_now;

    assign src_now = tb_src_e'(src_sel_i);

    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_XTAL;
        else     src_q <= src_now;
    end

    assign clr_o = (src_now != src_q);

    always_comb begin
        unique case (src_now)
            SRC_XTAL: tick_o = xtal_rise_i;
            SRC_SYS:  tick_o = 1'b1;
            SRC_PRE:  tick_o = pre_rise_i;
            default:  tick_o = 1'b0;
        endcase
    end

    // R8: a clear lasts one cycle once the select is steady
    a_r8_clear_once: assert property (@(posedge clk) disable iff (rst)
        (clr_o && $stable(src_sel_i)) |=> !clr_o);
endmodule

// File: rtl/tbase_divider.sv
module tbase_divider
    import tbase_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int NSHORT = N_SHORT,
    localparam int SEL_W = $clog2(NSHORT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] short_sel_i,
    output logic [W-1:0]     cnt_o,
    output logic             ovf_long_o,
    output logic             ovf_short_o
);
    logic [W-1:0]      cnt_q;
    logic [NSHORT-1:0] tap_hit;
    tb_wrap_s          hit;
    tb_wrap_s          pulse_q;

    for (genvar i = 0; i < NSHORT; i++) begin : g_tap
        localparam int TW = short_log(i);
        assign tap_hit[i] = &cnt_q[TW-1:0];
    end

    assign hit.long_hit  = &cnt_q;
    assign hit.short_hit = tap_hit[short_sel_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= '0;
        end else if (clr_i) begin
            cnt_q   <= '0;
            pulse_q <= '0;
        end else begin
            pulse_q <= tick_i ? hit : '0;
            if (tick_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o       = cnt_q;
    assign ovf_long_o  = pulse_q.long_hit;
    assign ovf_short_o = pulse_q.short_hit;

    a_r3_long_one_wide: assert property (@(posedge clk) disable iff (rst)
        ovf_long_o |=> !ovf_long_o);
    a_r5_short_one_wide: assert property (@(posedge clk) disable iff (rst)
        ovf_short_o |=> !ovf_short_o);
    a_r5_long_with_short: assert property (@(posedge clk) disable iff (rst)
        ovf_long_o |-> ovf_short_o);
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0 && !ovf_short_o && !ovf_long_o));
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clr_i) |=> ($stable(cnt_q) && !ovf_short_o));
endmodule

// File: rtl/tbase_tone.sv
module tbase_tone
    import tbase_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int NTONE = N_TONE,
    localparam int FSEL_W = (NTONE > 1) ? $clog2(NTONE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      cnt_i,
    input  logic              en_i,
    input  logic [FSEL_W-1:0] freq_i,
    output logic              buzz_o
);
    logic [NTONE-1:0] tap;
    logic             buzz_q;

    for (genvar i = 0; i < NTONE; i++) begin : g_tone
        assign tap[i] = cnt_i[tone_bit(i)];
    end

    always_ff @(posedge clk) begin
        if (rst) buzz_q <= 1'b0;
        else     buzz_q <= en_i & tap[freq_i];
    end

    assign buzz_o = buzz_q;

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !buzz_o);
endmodule

// File: rtl/tbase_buzz_top.sv
module tbase_buzz_top
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xtal_i,
    input  logic       pre_i,
    input  logic [1:0] src_sel_i,
    input  logic [1:0] short_sel_i,
    input  logic       buzz_en_i,
    input  logic       buzz_freq_i,
    output logic       ovf_long_o,
    output logic       ovf_short_o,
    output logic       buzz_o
);
    localparam int N_EXT = 2;

    logic [N_EXT-1:0] ext_lvl;
    logic [N_EXT-1:0] ext_rise;
    logic             tick;
    logic             clr;
    logic [CNT_W-1:0] cnt;

    assign ext_lvl = {pre_i, xtal_i};

    for (genvar i = 0; i < N_EXT; i++) begin : g_sync
        tbase_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (ext_lvl[i]),
            .rise_o  (ext_rise[i])
        );
    end

    tbase_src_sel i_src (
        .clk         (clk),
        .rst         (rst),
        .src_sel_i   (src_sel_i),
        .xtal_rise_i (ext_rise[0]),
        .pre_rise_i  (ext_rise[1]),
        .tick_o      (tick),
        .clr_o       (clr)
    );

    tbase_divider #(.W(CNT_W), .NSHORT(N_SHORT)) i_div (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .clr_i       (clr),
        .short_sel_i (short_sel_i),
        .cnt_o       (cnt),
        .ovf_long_o  (ovf_long_o),
        .ovf_short_o (ovf_short_o)
    );

    tbase_tone #(.W(CNT_W), .NTONE(N_TONE)) i_tone (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt),
        .en_i   (buzz_en_i),
        .freq_i (buzz_freq_i),
        .buzz_o (buzz_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!ovf_long_o && !ovf_short_o && !buzz_o));
endmodule

// File: tb/test_tbase_buzz_top.sv
module test_tbase_buzz_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xtal_i = 1'b0;
    logic       pre_i = 1'b0;
    logic [1:0] src_sel_i = 2'd1;
    logic [1:0] short_sel_i = 2'd0;
    logic       buzz_en_i = 1'b0;
    logic       buzz_freq_i = 1'b0;
    logic       ovf_long_o, ovf_short_o, buzz_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;            // 50 MHz
    always #80 xtal_i = ~xtal_i;      // period 8 system clocks
    always #60 pre_i = ~pre_i;        // period 6 system clocks

    tbase_buzz_top i_tbase_buzz_top (
        .clk(clk), .rst(rst), .xtal_i(xtal_i), .pre_i(pre_i),
        .src_sel_i(src_sel_i), .short_sel_i(short_sel_i),
        .buzz_en_i(buzz_en_i), .buzz_freq_i(buzz_freq_i),
        .ovf_long_o(ovf_long_o), .ovf_short_o(ovf_short_o), .buzz_o(buzz_o)
    );

    // src, short sel, expected interval in system clocks
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{1, 0, 32},
        '{1, 1, 128},
        '{1, 2, 512},
        '{1, 3, 2048},
        '{0, 0, 256},    // crystal: 32 ticks x 8 clocks
        '{2, 1, 768}     // prescaler: 128 ticks x 6 clocks
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input bit lng);
        return lng ? ovf_long_o : ovf_short_o;
    endfunction

    // Wait for a pulse, then measure its width and the gap to the next one.
    task automatic measure(input bit lng, output int ivl, output int wid);
        int n;
        ivl = -1; wid = -1;
        n = 0;
        while (pick(lng) !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
        if (n >= 40000) return;
        wid = 0;
        while (pick(lng) === 1'b1 && wid < 40000) begin @(negedge clk); wid++; end
        n = wid;
        while (pick(lng) !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
        if (n < 40000) ivl = n;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ivl, wid, hi, lo, n, pulses;
        logic held;

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 long in reset", int'(ovf_long_o), 0);
        check("R1 short in reset", int'(ovf_short_o), 0);
        check("R1 buzz in reset", int'(buzz_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after release", int'({ovf_long_o, ovf_short_o, buzz_o}), 0);

        // R2, R4, R5: vector table
        for (int v = 0; v < NVEC; v++) begin
            src_sel_i   = 2'(VEC[v][0]);
            short_sel_i = 2'(VEC[v][1]);
            measure(1'b0, ivl, wid);
            measure(1'b0, ivl, wid);
            check($sformatf("R4 R2 interval vec %0d", v), ivl, VEC[v][2]);
            check($sformatf("R5 width vec %0d", v), wid, 1);
        end

        // R3: long overflow with system clock source, R5 coincidence
        src_sel_i = 2'd1; short_sel_i = 2'd3;
        measure(1'b1, ivl, wid);
        n = 0;
        while (ovf_long_o !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
        check("R5 short with long", int'(ovf_short_o), 1);
        measure(1'b1, ivl, wid);
        check("R3 long interval", ivl, 16384);
        check("R3 long width", wid, 1);

        // R6: tone periods
        for (int f = 0; f < 2; f++) begin
            buzz_freq_i = 1'(f);
            buzz_en_i = 1'b1;
            repeat (40) @(negedge clk);
            n = 0;
            while (buzz_o !== 1'b0 && n < 100) begin @(negedge clk); n++; end
            while (buzz_o !== 1'b1 && n < 100) begin @(negedge clk); n++; end
            hi = 0; lo = 0;
            while (buzz_o === 1'b1 && hi < 100) begin @(negedge clk); hi++; end
            while (buzz_o === 1'b0 && lo < 100) begin @(negedge clk); lo++; end
            check($sformatf("R6 high time tone %0d", f), hi, 4 << f);
            check($sformatf("R6 low time tone %0d", f), lo, 4 << f);
        end

        // R7: disabled tone stays low while counting
        buzz_en_i = 1'b0;
        @(negedge clk);
        n = 0;
        for (int k = 0; k < 64; k++) begin @(negedge clk); if (buzz_o !== 1'b0) n++; end
        check("R7 buzz high samples while off", n, 0);

        // R8: source change clears the divider
        src_sel_i = 2'd1; short_sel_i = 2'd0;
        repeat (13) @(negedge clk);
        src_sel_i = 2'd0;
        repeat (5) @(negedge clk);
        src_sel_i = 2'd1;
        n = 0;
        do begin @(negedge clk); n++; end while (ovf_short_o !== 1'b1 && n < 200);
        check("R8 first short after switch", n, 33);

        // R9: stopped source holds everything
        buzz_en_i = 1'b1; buzz_freq_i = 1'b0;
        repeat (3) @(negedge clk);
        src_sel_i = 2'd3;
        repeat (2) @(negedge clk);
        held = buzz_o;
        pulses = 0; n = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (ovf_short_o === 1'b1 || ovf_long_o === 1'b1) pulses++;
            if (buzz_o !== held) n++;
        end
        check("R9 pulses while stopped", pulses, 0);
        check("R9 buzz changes while stopped", n, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule